// File: doc/BRIEF.md
# Ring Command Buffer Processor

This block drains a circular queue of 16-byte commands that software places in system memory. Software programs the ring's page-aligned base address and its size exponent, moves the tail pointer to publish new commands, and turns on two enable bits. While both enables are set and head differs from tail, the block fetches the command at head with two 64-bit memory reads, decodes a 4-bit opcode, and carries it out. It then advances head by one entry, wrapping at the end of the ring.

The completion-wait opcode can store an 8-byte value to memory, raise a sticky status flag, or do both. The device-invalidate opcode emits a one-cycle pulse that carries a 16-bit device/function number toward the translation-cache logic. Every other opcode is consumed without side effects. Head and tail are byte offsets on entry boundaries. Writing the base register restarts the ring with both pointers at zero.

Top module: `cmdring_proc`

## Requirements
- R1: After reset, head, tail and control read as zero, status reads zero, no memory request or invalidate pulse is active, and the base register reads with size exponent 8 in bits 59:56.
- R2: A write to the head or tail register (select 2 or 3) keeps only bits 18:4 of the written value. All other bits read back as zero.
- R3: A write to the base register (select 0) loads the base address from bits 51:12 and the size exponent from bits 59:56, and clears head and tail to zero.
- R4: Commands are fetched only while control bit 0 and control bit 12 (select 1) are both set. Status bit 4 (select 4) reads as the AND of those two bits.
- R5: Each command is fetched as a read at base plus fetch pointer, then a read at that address plus 8. Read and write requests are never active together.
- R6: After a command completes, head becomes fetch pointer plus 16, or zero when that sum reaches 16 times 2 to the power of the size exponent. A head at or beyond that limit fetches from offset zero.
- R7: Opcode 1 (bits 63:60 of the first word) with bit 0 set writes the second word to the address formed by bits 51:3 of the first word, with the low three bits zero.
- R8: Opcode 1 with bit 1 set sets status bit 2, which stays set until reset.
- R9: Opcode 4 produces a one-cycle invalidate pulse carrying bits 15:0 of the first word. Any other opcode besides 1 and 4 causes no write and no pulse, and still advances head. Flag bits 1:0 are ignored outside opcode 1.
- R10: Processing continues until head equals tail, stops when an enable is cleared, and resumes when the enables are set again or tail is moved.
- R11: The head register changes only on a register write or when a command completes, so software sees head step once per finished command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 base, 1 control, 2 head, 3 tail, 4 status |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Read data for the selected register |
| mem_rd_req | output | 1 | Memory read request, held until mem_rd_valid |
| mem_rd_addr | output | 52 | Memory read address |
| mem_rd_valid | input | 1 | Read data valid, completes the request |
| mem_rd_data | input | 64 | Read data |
| mem_wr_req | output | 1 | Memory write request, held until mem_wr_ack |
| mem_wr_addr | output | 52 | Memory write address |
| mem_wr_data | output | 64 | Memory write data |
| mem_wr_ack | input | 1 | Write accepted |
| inval_pulse | output | 1 | One-cycle device invalidate strobe |
| inval_devfn | output | 16 | Device/function number for the invalidate |

## Verification
The hardest situations to reach are the ring edges. One is head walking off the last slot and wrapping to zero while commands remain. Another is a head that software has set beyond the ring limit. A third is head being observed while a command is still partly fetched. The stimulus places tail numerically behind head so that the drain must wrap. It writes an out-of-range head directly, and it shrinks the ring to two entries so that a wrap happens every other command. It also stretches the memory response latency so that a head read lands between the fetch and the completion of a single command.

// File: rtl/cmdring_pkg.sv
`timescale 1ns/1ps
package cmdring_pkg;
  localparam int unsigned RING_PTR_W  = 19;
  localparam int unsigned RING_LIM_W  = RING_PTR_W + 1;
  localparam int unsigned ENTRY_SHIFT = 4;
  localparam int unsigned ENTRY_BYTES = 1 << ENTRY_SHIFT;
  localparam int unsigned WORD_BYTES  = 8;
  localparam int unsigned PG_SHIFT    = 12;
  localparam int unsigned SIZE_LSB    = 56;
  localparam int unsigned SIZE_W      = 4;
  localparam logic [SIZE_W-1:0] SIZE_RESET = 4'd8;
  localparam int unsigned EN_GLOBAL_BIT = 0;
  localparam int unsigned EN_RING_BIT   = 12;
  localparam int unsigned ST_FLAG_BIT   = 2;
  localparam int unsigned ST_RUN_BIT    = 4;
  localparam int unsigned OPC_LSB     = 60;
  localparam int unsigned OPC_W       = 4;
  localparam int unsigned STORE_BIT   = 0;
  localparam int unsigned IRQ_BIT     = 1;
  localparam int unsigned DEVFN_W     = 16;
  localparam logic [OPC_W-1:0] OPC_WAIT    = 4'd1;
  localparam logic [OPC_W-1:0] OPC_DEV_INV = 4'd4;
  localparam logic [2:0] SEL_BASE = 3'd0;
  localparam logic [2:0] SEL_CTRL = 3'd1;
  localparam logic [2:0] SEL_HEAD = 3'd2;
  localparam logic [2:0] SEL_TAIL = 3'd3;
  localparam logic [2:0] SEL_STAT = 3'd4;

  typedef logic [RING_PTR_W-1:0] ring_ptr_t;
  typedef logic [RING_LIM_W-1:0] ring_lim_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_LO, ST_RD_HI, ST_EXEC, ST_STORE
  } eng_state_t;

  // ring length in bytes: entries (2^exp) times entry size
  function automatic ring_lim_t ring_limit(input logic [SIZE_W-1:0] e);
    return ring_lim_t'(1) << (int'(e) + int'(ENTRY_SHIFT));
  endfunction

  // keep only the entry-aligned pointer bits of a written value
  function automatic ring_ptr_t ptr_clip(input logic [63:0] v);
    return {v[RING_PTR_W-1:ENTRY_SHIFT], {ENTRY_SHIFT{1'b0}}};
  endfunction

  // a pointer outside the ring is treated as slot zero
  function automatic ring_ptr_t fetch_ptr(input ring_ptr_t h, input ring_lim_t lim);
    return (ring_lim_t'(h) >= lim) ? '0 : h;
  endfunction

  function automatic ring_ptr_t advance_ptr(input ring_ptr_t p, input ring_lim_t lim);
    ring_lim_t s;
    s = ring_lim_t'(p) + ring_lim_t'(ENTRY_BYTES);
    return (s >= lim) ? '0 : s[RING_PTR_W-1:0];
  endfunction
endpackage

// File: rtl/cmdring_regs.sv
`timescale 1ns/1ps
module cmdring_regs
  import cmdring_pkg::*;
#(
  parameter int unsigned ADDR_W = 52
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_sel,
  input  logic [63:0]       reg_wdata,
  output logic [63:0]       reg_rdata,
  input  logic              adv_en,
  input  ring_ptr_t         adv_ptr,
  input  logic              flag_set,
  output logic [ADDR_W-1:0] ring_base,
  output ring_lim_t         ring_lim,
  output ring_ptr_t         head,
  output ring_ptr_t         tail,
  output logic              run,
  output logic              wait_flag
);
  localparam int unsigned PG_W = ADDR_W - PG_SHIFT;

  logic [PG_W-1:0]   base_pg_q;
  logic [SIZE_W-1:0] size_q;
  logic              en_g_q, en_r_q;
  ring_ptr_t         head_q, tail_q;
  logic              flag_q;
  logic              unused_wbits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_pg_q <= '0;
      size_q    <= SIZE_RESET;
      en_g_q    <= 1'b0;
      en_r_q    <= 1'b0;
      head_q    <= '0;
      tail_q    <= '0;
      flag_q    <= 1'b0;
    end else begin
      if (flag_set) flag_q <= 1'b1;
      if (adv_en)   head_q <= adv_ptr;
      // a software write overrides a completion in the same cycle
      if (reg_we) begin
        unique case (reg_sel)
          SEL_BASE: begin
            base_pg_q <= reg_wdata[ADDR_W-1:PG_SHIFT];
            size_q    <= reg_wdata[SIZE_LSB +: SIZE_W];
            head_q    <= '0;
            tail_q    <= '0;
          end
          SEL_CTRL: begin
            en_g_q <= reg_wdata[EN_GLOBAL_BIT];
            en_r_q <= reg_wdata[EN_RING_BIT];
          end
          SEL_HEAD: head_q <= ptr_clip(reg_wdata);
          SEL_TAIL: tail_q <= ptr_clip(reg_wdata);
          default: ;
        endcase
      end
    end
  end

  assign unused_wbits = ^{reg_wdata[63:SIZE_LSB+SIZE_W], reg_wdata[SIZE_LSB-1:ADDR_W]};

  assign ring_base = {base_pg_q, {PG_SHIFT{1'b0}}};
  assign ring_lim  = ring_limit(size_q);
  assign head      = head_q;
  assign tail      = tail_q;
  assign run       = en_g_q & en_r_q;
  assign wait_flag = flag_q;

  always_comb begin
    reg_rdata = '0;
    unique case (reg_sel)
      SEL_BASE: begin
        reg_rdata[ADDR_W-1:PG_SHIFT]    = base_pg_q;
        reg_rdata[SIZE_LSB +: SIZE_W]   = size_q;
      end
      SEL_CTRL: begin
        reg_rdata[EN_GLOBAL_BIT] = en_g_q;
        reg_rdata[EN_RING_BIT]   = en_r_q;
      end
      SEL_HEAD: reg_rdata[RING_PTR_W-1:0] = head_q;
      SEL_TAIL: reg_rdata[RING_PTR_W-1:0] = tail_q;
      SEL_STAT: begin
        reg_rdata[ST_FLAG_BIT] = flag_q;
        reg_rdata[ST_RUN_BIT]  = en_g_q & en_r_q;
      end
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/cmdring_engine.sv
`timescale 1ns/1ps
module cmdring_engine
  import cmdring_pkg::*;
#(
  parameter int unsigned ADDR_W = 52
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  ring_ptr_t          head,
  input  ring_ptr_t          tail,
  input  ring_lim_t          ring_lim,
  input  logic [ADDR_W-1:0]  ring_base,
  output logic               mem_rd_req,
  output logic [ADDR_W-1:0]  mem_rd_addr,
  input  logic               mem_rd_valid,
  input  logic [63:0]        mem_rd_data,
  output logic               mem_wr_req,
  output logic [ADDR_W-1:0]  mem_wr_addr,
  output logic [63:0]        mem_wr_data,
  input  logic               mem_wr_ack,
  output logic               inval_pulse,
  output logic [DEVFN_W-1:0] inval_devfn,
  output logic               cmd_done,
  output ring_ptr_t          adv_ptr,
  output logic               flag_set
);
  eng_state_t       state_q;
  ring_ptr_t        ptr_q;
  logic [63:0]      lo_q, hi_q;
  logic             inval_q;
  logic [OPC_W-1:0] opc;
  logic             want_store, want_flag;
  logic             unused_lo;

  assign opc        = lo_q[OPC_LSB +: OPC_W];
  assign want_store = (opc == OPC_WAIT) && lo_q[STORE_BIT];
  assign want_flag  = (opc == OPC_WAIT) && lo_q[IRQ_BIT];
  assign unused_lo  = ^{lo_q[OPC_LSB-1:ADDR_W], lo_q[2]};

  assign cmd_done = ((state_q == ST_EXEC) && !want_store) ||
                    ((state_q == ST_STORE) && mem_wr_ack);
  assign adv_ptr  = advance_ptr(ptr_q, ring_lim);
  assign flag_set = cmd_done && want_flag;

  assign mem_rd_req  = (state_q == ST_RD_LO) || (state_q == ST_RD_HI);
  assign mem_rd_addr = ring_base + ADDR_W'(ptr_q) +
                       ((state_q == ST_RD_HI) ? ADDR_W'(WORD_BYTES) : '0);
  assign mem_wr_req  = (state_q == ST_STORE);
  assign mem_wr_addr = {lo_q[ADDR_W-1:3], 3'b000};
  assign mem_wr_data = hi_q;
  assign inval_pulse = inval_q;
  assign inval_devfn = lo_q[DEVFN_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
      inval_q <= 1'b0;
    end else begin
      inval_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (run && (head != tail)) begin
          ptr_q   <= fetch_ptr(head, ring_lim);
          state_q <= ST_RD_LO;
        end
        ST_RD_LO: if (mem_rd_valid) begin
          lo_q    <= mem_rd_data;
          state_q <= ST_RD_HI;
        end
        ST_RD_HI: if (mem_rd_valid) begin
          hi_q    <= mem_rd_data;
          state_q <= ST_EXEC;
        end
        ST_EXEC: begin
          inval_q <= (opc == OPC_DEV_INV);
          state_q <= want_store ? ST_STORE : ST_IDLE;
        end
        ST_STORE: if (mem_wr_ack) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cmdring_proc.sv
`timescale 1ns/1ps
module cmdring_proc
  import cmdring_pkg::*;
#(
  parameter int unsigned ADDR_W = 52
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_sel,
  input  logic [63:0]       reg_wdata,
  output logic [63:0]       reg_rdata,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_valid,
  input  logic [63:0]       mem_rd_data,
  output logic              mem_wr_req,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [63:0]       mem_wr_data,
  input  logic              mem_wr_ack,
  output logic              inval_pulse,
  output logic [15:0]       inval_devfn
);
  logic [ADDR_W-1:0] base_w;
  ring_lim_t         lim_w;
  ring_ptr_t         head_w, tail_w, adv_ptr_w;
  logic              run_w, flag_w, done_w, flag_set_w;

  cmdring_regs #(.ADDR_W(ADDR_W)) regs_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .adv_en    (done_w),
    .adv_ptr   (adv_ptr_w),
    .flag_set  (flag_set_w),
    .ring_base (base_w),
    .ring_lim  (lim_w),
    .head      (head_w),
    .tail      (tail_w),
    .run       (run_w),
    .wait_flag (flag_w)
  );

  cmdring_engine #(.ADDR_W(ADDR_W)) eng_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .run          (run_w),
    .head         (head_w),
    .tail         (tail_w),
    .ring_lim     (lim_w),
    .ring_base    (base_w),
    .mem_rd_req   (mem_rd_req),
    .mem_rd_addr  (mem_rd_addr),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_data  (mem_rd_data),
    .mem_wr_req   (mem_wr_req),
    .mem_wr_addr  (mem_wr_addr),
    .mem_wr_data  (mem_wr_data),
    .mem_wr_ack   (mem_wr_ack),
    .inval_pulse  (inval_pulse),
    .inval_devfn  (inval_devfn),
    .cmd_done     (done_w),
    .adv_ptr      (adv_ptr_w),
    .flag_set     (flag_set_w)
  );
endmodule

// File: rtl/cmdring_chk.sv
`timescale 1ns/1ps
module cmdring_chk
  import cmdring_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       reg_we,
  input logic [2:0] reg_sel,
  input logic       run_w,
  input logic       done_w,
  input logic       flag_w,
  input logic       mem_rd_req,
  input logic       mem_wr_req,
  input logic       inval_pulse,
  input ring_ptr_t  head_w,
  input ring_ptr_t  tail_w,
  input ring_lim_t  lim_w
);
  // R3
  base_clears_ptrs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel == SEL_BASE) |=> (head_w == '0 && tail_w == '0));

  // R4
  fetch_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_rd_req) |-> $past(run_w));

  // R5
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_req |-> !mem_rd_req);

  // R6
  head_in_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_w && !reg_we) |=> (ring_lim_t'(head_w) < lim_w && head_w[3:0] == 4'd0));

  // R8
  flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_w) |-> $past(done_w));

  // R9
  inval_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inval_pulse |=> !inval_pulse);

  // R11
  head_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (head_w != $past(head_w)) |-> ($past(reg_we) || $past(done_w)));
endmodule

bind cmdring_proc cmdring_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_we      (reg_we),
  .reg_sel     (reg_sel),
  .run_w       (run_w),
  .done_w      (done_w),
  .flag_w      (flag_w),
  .mem_rd_req  (mem_rd_req),
  .mem_wr_req  (mem_wr_req),
  .inval_pulse (inval_pulse),
  .head_w      (head_w),
  .tail_w      (tail_w),
  .lim_w       (lim_w)
);

// File: tb/cmdring_proc_tb_top.sv
`timescale 1ns/1ps
module cmdring_proc_tb_top;
  import cmdring_pkg::*;
  localparam int AW = 52;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          reg_we;
  logic [2:0]    reg_sel;
  logic [63:0]   reg_wdata, reg_rdata;
  logic          mem_rd_req, mem_rd_valid, mem_wr_req, mem_wr_ack;
  logic [AW-1:0] mem_rd_addr, mem_wr_addr;
  logic [63:0]   mem_rd_data, mem_wr_data;
  logic          inval_pulse;
  logic [15:0]   inval_devfn;

  always #10 clk = ~clk;

  cmdring_proc #(.ADDR_W(AW)) dut_i (.*);

  int n_chk = 0, n_fail = 0, lat = 0, rc = 0, wc = 0;
  bit finished = 0;
  logic [63:0] mem_a [logic [AW-1:0]];
  int          kq[$];
  logic [63:0] vq[$];
  logic [AW-1:0] m_base;
  longint m_lim, m_head, m_tail;
  bit m_g, m_c, m_flag;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, expv);
    end
  endtask

  function automatic logic [63:0] rdmem(input logic [AW-1:0] a);
    return mem_a.exists(a) ? mem_a[a] : 64'h0;
  endfunction

  task automatic push_ev(input int k, input logic [63:0] v);
    kq.push_back(k);
    vq.push_back(v);
  endtask

  task automatic ev_check(input int k, input logic [63:0] v, input string req);
    if (kq.size() == 0) begin
      chk(1'b0, req, v, 64'h0);
    end else begin
      int ek;
      logic [63:0] ev;
      ek = kq.pop_front();
      ev = vq.pop_front();
      chk(ek == k && ev == v, req, v, ev);
    end
  endtask

  // behavioural drain of the ring: list every bus event in order
  task automatic model_run();
    while (m_head != m_tail) begin
      longint p, n;
      logic [AW-1:0] a;
      logic [63:0] lo, hi;
      p  = (m_head >= m_lim) ? 0 : m_head;
      a  = m_base + AW'(p);
      lo = rdmem(a);
      hi = rdmem(a + AW'(8));
      push_ev(0, 64'(a));
      push_ev(0, 64'(a + AW'(8)));
      if (lo[63:60] == 4'd1 && lo[0]) begin
        push_ev(1, {12'h0, lo[51:3], 3'b000});
        push_ev(2, hi);
      end
      if (lo[63:60] == 4'd4) push_ev(3, {48'h0, lo[15:0]});
      if (lo[63:60] == 4'd1 && lo[1]) m_flag = 1;
      n = p + 16;
      m_head = (n >= m_lim) ? 0 : n;
    end
  endtask

  task automatic sw(input logic [2:0] s, input logic [63:0] v);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = s; reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
    case (s)
      SEL_BASE: begin
        m_base = {v[AW-1:12], 12'h0};
        m_lim  = longint'(16) << v[59:56];
        m_head = 0; m_tail = 0;
      end
      SEL_CTRL: begin m_g = v[0]; m_c = v[12]; end
      SEL_HEAD: m_head = longint'(v & 64'h7FFF0);
      SEL_TAIL: m_tail = longint'(v & 64'h7FFF0);
      default: ;
    endcase
    if (m_g && m_c) model_run();
  endtask

  task automatic rd(input logic [2:0] s, output logic [63:0] v);
    @(negedge clk);
    reg_sel = s;
    #1 v = reg_rdata;
  endtask

  task automatic chk_reg(input logic [2:0] s, input logic [63:0] e, input string req);
    logic [63:0] v;
    rd(s, v);
    chk(v === e, req, v, e);
  endtask

  function automatic logic [63:0] exp_stat();
    return (64'(m_g && m_c) << 4) | (64'(m_flag) << 2);
  endfunction

  task automatic wait_idle(input string req);
    logic [63:0] h;
    int t;
    t = 0;
    do begin
      rd(SEL_HEAD, h);
      t++;
    end while ((kq.size() != 0 || h != 64'(m_head)) && t < 3000);
    chk(kq.size() == 0 && h == 64'(m_head), req, h, 64'(m_head));
    repeat (4) @(negedge clk);
  endtask

  task automatic put(input logic [AW-1:0] b, input int slot, input logic [63:0] lo, input logic [63:0] hi);
    mem_a[b + AW'(slot * 16)]     = lo;
    mem_a[b + AW'(slot * 16 + 8)] = hi;
  endtask

  // memory responder and per-clock comparison against the model
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_rd_valid = 1'b0; mem_wr_ack = 1'b0; rc = 0; wc = 0;
    end else begin
      mem_rd_valid = 1'b0;
      mem_wr_ack   = 1'b0;
      if (mem_rd_req && mem_wr_req) chk(1'b0, "R5", 64'h1, 64'h0);
      if (mem_rd_req) begin
        if (rc >= lat) begin
          rc = 0;
          mem_rd_valid = 1'b1;
          mem_rd_data  = rdmem(mem_rd_addr);
          ev_check(0, 64'(mem_rd_addr), "R5");
        end else rc++;
      end else rc = 0;
      if (mem_wr_req) begin
        if (wc >= lat) begin
          wc = 0;
          mem_wr_ack = 1'b1;
          ev_check(1, 64'(mem_wr_addr), "R7");
          ev_check(2, mem_wr_data, "R7");
        end else wc++;
      end else wc = 0;
      if (inval_pulse) ev_check(3, {48'h0, inval_devfn}, "R9");
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL R10 watchdog act=running exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  localparam logic [AW-1:0] B1 = 52'h0_0000_1234_5000;
  localparam logic [AW-1:0] B2 = 52'h0_0000_0777_7000;

  initial begin
    logic [63:0] v;
    rst_n = 1'b0; reg_we = 1'b0; reg_sel = '0; reg_wdata = '0;
    mem_rd_valid = 1'b0; mem_wr_ack = 1'b0; mem_rd_data = '0;
    m_base = '0; m_lim = 16 << 8; m_head = 0; m_tail = 0;
    m_g = 0; m_c = 0; m_flag = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk_reg(SEL_BASE, 64'h0800_0000_0000_0000, "R1");
    chk_reg(SEL_CTRL, 64'h0, "R1");
    chk_reg(SEL_HEAD, 64'h0, "R1");
    chk_reg(SEL_TAIL, 64'h0, "R1");
    chk_reg(SEL_STAT, 64'h0, "R1");
    chk(!mem_rd_req && !mem_wr_req && !inval_pulse, "R1",
        {61'h0, mem_rd_req, mem_wr_req, inval_pulse}, 64'h0);

    // R2 pointer masking
    sw(SEL_HEAD, 64'hFFFF_FFFF_FFFF_FFFF);
    chk_reg(SEL_HEAD, 64'h7FFF0, "R2");
    sw(SEL_TAIL, 64'h1234_5678_9ABC_DEF7);
    chk_reg(SEL_TAIL, 64'h1234_5678_9ABC_DEF7 & 64'h7FFF0, "R2");

    // R3 base write: 8-entry ring
    sw(SEL_BASE, 64'h0300_0000_0000_0000 | 64'(B1) | 64'hFFF);
    chk_reg(SEL_BASE, 64'h0300_0000_0000_0000 | 64'(B1), "R3");
    chk_reg(SEL_HEAD, 64'h0, "R3");
    chk_reg(SEL_TAIL, 64'h0, "R3");

    put(B1, 0, 64'h1000_0000_8000_0041, 64'hCAFE_0000_0000_0001);
    put(B1, 1, 64'h4000_0000_0000_00A5, 64'h0);
    put(B1, 2, 64'h2000_0000_0000_0003, 64'h0);
    put(B1, 3, 64'h1000_0000_0000_0002, 64'h0);
    put(B1, 4, 64'h3000_0000_0000_0001, 64'h0);
    put(B1, 5, 64'h5000_0000_0000_0002, 64'h0);
    put(B1, 6, 64'h1000_0000_9000_0013, 64'h1122_3344_5566_7788);
    put(B1, 7, 64'hF000_0000_0000_0003, 64'h0);

    // R4 gating by both enables
    sw(SEL_TAIL, 64'h20);
    repeat (20) @(negedge clk);
    chk_reg(SEL_HEAD, 64'h0, "R4");
    sw(SEL_CTRL, 64'h1);
    repeat (20) @(negedge clk);
    chk_reg(SEL_HEAD, 64'h0, "R4");
    chk_reg(SEL_STAT, exp_stat(), "R4");
    sw(SEL_CTRL, 64'h1000);
    repeat (20) @(negedge clk);
    chk_reg(SEL_HEAD, 64'h0, "R4");
    sw(SEL_CTRL, 64'h1001);
    chk_reg(SEL_STAT, 64'h10, "R4");
    wait_idle("R6");
    chk_reg(SEL_STAT, exp_stat(), "R8");

    // R9 skipped opcodes and R8 flag
    sw(SEL_TAIL, 64'h60);
    wait_idle("R9");
    chk_reg(SEL_STAT, 64'h14, "R8");

    // R6 wrap with slower memory
    put(B1, 0, 64'h4000_0000_0000_BEEF, 64'h0);
    put(B1, 1, 64'h1000_0000_8000_0101, 64'h0F0F_F0F0_0000_0042);
    lat = 3;
    sw(SEL_TAIL, 64'h20);
    wait_idle("R6");

    // R6 out-of-range head fetches from slot zero
    lat = 1;
    sw(SEL_HEAD, 64'h200);
    wait_idle("R6");
    chk_reg(SEL_HEAD, 64'h20, "R6");

    // R10 stop and resume
    sw(SEL_CTRL, 64'h0);
    sw(SEL_TAIL, 64'h40);
    repeat (30) @(negedge clk);
    chk_reg(SEL_HEAD, 64'h20, "R10");
    sw(SEL_CTRL, 64'h1001);
    wait_idle("R10");

    // R11 and R6 on a two-entry ring
    sw(SEL_BASE, 64'h0100_0000_0000_0000 | 64'(B2));
    put(B2, 0, 64'h2000_0000_0000_0000, 64'h0);
    put(B2, 1, 64'h4000_0000_0000_0123, 64'h0);
    lat = 15;
    sw(SEL_TAIL, 64'h10);
    repeat (10) @(negedge clk);
    chk_reg(SEL_HEAD, 64'h0, "R11");
    wait_idle("R11");
    chk_reg(SEL_HEAD, 64'h10, "R11");
    lat = 0;
    sw(SEL_TAIL, 64'h0);
    wait_idle("R6");
    chk_reg(SEL_HEAD, 64'h0, "R6");
    chk(kq.size() == 0, "R5", 64'(kq.size()), 64'h0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule